// File: doc/BRIEF.md
# Multi-Function Sequencing Pin Controller

This block holds the digital control for one configurable pin of a power-management controller. The pin has two roles, and a configuration input picks one. It samples that input once after reset and keeps the role until the next reset. In the general-purpose role, a direction bit sets the pin as an input or an output.

As an input, the pin acts as a gate in the power-up sequencer. The pin level is synchronised and compared against a programmable on level. When the sequencer reaches the slot assigned to the pin, the block holds the sequencer until that level appears. If the level stays absent for the full timeout window (80 ms by default), the block sets a sticky fault flag and raises a one-cycle request to return to the initialise state.

As an output, the pin follows either a register enable bit or the sequencer reaching the pin's slot. An active output is released high. In the voltage-select role, the pin is read as a three-level state (low, open, high) and decoded into a target voltage choice for one of two regulator rails.

Top module: `mfp_pin_ctrl`

## Requirements
- R1: The role input is captured on the first clock edge after reset release: 0 is general-purpose, 1 is voltage-select. Later changes have no effect until the next reset.
- R2: In the general-purpose role, direction 0 makes the pin an output (`pin_oe_o`=1) and direction 1 makes it an input (`pin_oe_o`=0). Direction may change at any time and takes effect at once.
- R3: In input mode, `seq_hold_o` is 1 when the sequencer is active at the assigned slot and the synchronised level differs from `on_pol_i`. The level counts as 1 only for pin code 2'b10. Because of the two-flop synchroniser, a pin change reaches `seq_hold_o` two clocks later.
- R4: After CLK_HZ/1000*TIMEOUT_MS consecutive holding clock edges, `timeout_o` becomes 1 and `init_req_o` is 1 for exactly one cycle. Neither is raised one edge earlier.
- R5: The timeout count restarts when the wait ends and a new wait begins. It also restarts on any cycle with `seq_abort_i`=1.
- R6: `timeout_o` stays set until a `timeout_clr_i` strobe, and clears on the edge after that strobe.
- R7: In output mode with register source (`out_src_seq_i`=0), `pin_out_o` equals `gpio_en_i`.
- R8: In output mode with sequencer source, `pin_out_o` goes to 1 on the edge after the sequencer is active at the assigned slot. It stays 1 while the slot advances and `gpio_en_i` changes, and returns to 0 after `seq_abort_i`.
- R9: In the voltage-select role with rail bit 0 (rail 1), pin codes decode as follows. Low (00) gives code 0 (register value, 0 mV). Open (01, and the invalid 11) gives code 1 at 750 mV. High (10) gives code 2 at 1100 mV.
- R10: With rail bit 1 (rail 3), low gives code 0 (0 mV), open gives code 1 at 1100 mV, and high gives code 2 at 1200 mV.
- R11: The voltage-select outputs change one clock after the pin code changes. In the voltage-select role, `pin_oe_o` and `seq_hold_o` stay 0 whatever the direction and sequencer inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| role_vsel_i | input | 1 | Role select: 0 general-purpose, 1 voltage-select |
| dir_in_i | input | 1 | Direction: 0 output, 1 input |
| on_pol_i | input | 1 | On level for input gating |
| out_src_seq_i | input | 1 | Output source: 0 register bit, 1 sequencer |
| gpio_en_i | input | 1 | Register enable for the output |
| assign_slot_i | input | SLOT_W | Sequencer slot assigned to the pin |
| seq_active_i | input | 1 | Sequencer is running |
| seq_slot_i | input | SLOT_W | Current sequencer slot |
| seq_abort_i | input | 1 | Sequence abort; clears the wait counter and the output latch |
| timeout_clr_i | input | 1 | Write-one-to-clear strobe for the timeout flag |
| pin_code_i | input | 2 | Sensed pin state: 00 low, 01 open, 10 high, 11 open |
| rail_sel_i | input | 1 | Target rail: 0 rail 1, 1 rail 3 |
| pin_oe_o | output | 1 | Pin acts as output |
| pin_out_o | output | 1 | Output level (1 released high) |
| seq_hold_o | output | 1 | Sequencer must hold at this slot |
| timeout_o | output | 1 | Sticky wait-timeout flag |
| init_req_o | output | 1 | One-cycle request to enter initialise state |
| vsel_valid_o | output | 1 | Voltage-select role active |
| vsel_rail_o | output | 1 | Rail the selection applies to |
| vsel_code_o | output | 2 | 0 register value, 1 fixed low, 2 fixed high |
| vsel_mv_o | output | MV_W | Fixed target in millivolts (0 for register value) |

## Verification
The hardest situation to reach is the timeout boundary. It needs thousands of uninterrupted holding cycles, and an interruption or abort at an arbitrary point must restart the count. The bench overrides CLK_HZ so the window is 4000 clocks. It parks the sequencer on the assigned slot with the pin at the wrong level and samples one edge before and exactly at expiry. It then repeats the run after a dropped wait and after a mid-wait abort, so that a counter which fails to restart would fire early. The role freeze is reached by reset cycles with different role values, followed by toggling the role input afterwards.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;
  typedef enum logic [1:0] {
    PIN_LOW  = 2'b00,
    PIN_OPEN = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_BAD  = 2'b11
  } pin_code_e;

  typedef enum logic [1:0] {
    VS_REG    = 2'd0,
    VS_FIX_LO = 2'd1,
    VS_FIX_HI = 2'd2
  } vsel_code_e;
endpackage

// File: rtl/mfp_sync.sv
`timescale 1ns/1ps
module mfp_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mfp_seq_gate.sv
`timescale 1ns/1ps
module mfp_seq_gate #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_MS = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic seq_active_i,
  input  logic at_slot_i,
  input  logic level_i,
  input  logic on_pol_i,
  input  logic abort_i,
  input  logic clr_i,
  output logic hold_o,
  output logic timeout_o,
  output logic init_req_o
);
  localparam int PRESC   = (CLK_HZ / 1000 < 2) ? 2 : CLK_HZ / 1000;
  localparam int PRESC_W = $clog2(PRESC);
  localparam int MS_N    = (TIMEOUT_MS < 1) ? 1 : TIMEOUT_MS;
  localparam int MS_W    = (MS_N < 2) ? 1 : $clog2(MS_N);
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC - 1);
  localparam logic [MS_W-1:0]    MS_LAST    = MS_W'(MS_N - 1);

  logic [PRESC_W-1:0] presc_q;
  logic [MS_W-1:0]    ms_q;
  logic fired_q, timeout_q, init_q;
  logic wait_c, match_c, count_c, fire_c;

  assign wait_c  = en_i & seq_active_i & at_slot_i;
  assign match_c = (level_i == on_pol_i);
  assign hold_o  = wait_c & ~match_c;
  assign count_c = hold_o & ~fired_q & ~abort_i;
  assign fire_c  = count_c & (presc_q == PRESC_LAST) & (ms_q == MS_LAST);

  // window counter: restarts whenever the wait drops or is aborted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      ms_q    <= '0;
      fired_q <= 1'b0;
    end else if (!wait_c || abort_i) begin
      presc_q <= '0;
      ms_q    <= '0;
      fired_q <= 1'b0;
    end else if (count_c) begin
      if (presc_q == PRESC_LAST) begin
        presc_q <= '0;
        if (ms_q == MS_LAST) fired_q <= 1'b1;
        else                 ms_q    <= ms_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= 1'b0;
      init_q    <= 1'b0;
    end else begin
      init_q <= fire_c;
      if (fire_c)     timeout_q <= 1'b1;
      else if (clr_i) timeout_q <= 1'b0;
    end
  end

  assign timeout_o  = timeout_q;
  assign init_req_o = init_q;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_q && !clr_i |=> timeout_q);
  p_init_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> !init_q);
  p_fire_in_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_q) |-> $past(hold_o) && !$past(abort_i));
  p_abort_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !init_q);
endmodule

// File: rtl/mfp_out_ctl.sv
`timescale 1ns/1ps
module mfp_out_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic src_seq_i,
  input  logic gpio_en_i,
  input  logic seq_active_i,
  input  logic at_slot_i,
  input  logic abort_i,
  output logic pin_out_o
);
  logic seq_q;
  logic seq_mode_c;

  assign seq_mode_c = en_i & src_seq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     seq_q <= 1'b0;
    else if (!seq_mode_c || abort_i) seq_q <= 1'b0;
    else if (seq_active_i && at_slot_i) seq_q <= 1'b1;
  end

  assign pin_out_o = en_i & (src_seq_i ? seq_q : gpio_en_i);

  p_seq_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_mode_c && !abort_i && seq_q |=> seq_q);
  p_seq_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !seq_q);
endmodule

// File: rtl/mfp_vsel_dec.sv
`timescale 1ns/1ps
module mfp_vsel_dec
  import mfp_pkg::*;
#(
  parameter int MV_W      = 11,
  parameter int R1_LO_MV  = 750,
  parameter int R1_HI_MV  = 1100,
  parameter int R3_LO_MV  = 1100,
  parameter int R3_HI_MV  = 1200
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            rail_i,
  input  logic [1:0]      pin_code_i,
  output logic            rail_o,
  output logic [1:0]      code_o,
  output logic [MV_W-1:0] mv_o
);
  localparam logic [MV_W-1:0] MV_R1_LO = MV_W'(R1_LO_MV);
  localparam logic [MV_W-1:0] MV_R1_HI = MV_W'(R1_HI_MV);
  localparam logic [MV_W-1:0] MV_R3_LO = MV_W'(R3_LO_MV);
  localparam logic [MV_W-1:0] MV_R3_HI = MV_W'(R3_HI_MV);

  pin_code_e       pin_c;
  vsel_code_e      code_c, code_q;
  logic [MV_W-1:0] mv_c, mv_q;
  logic            rail_q;

  assign pin_c = pin_code_e'(pin_code_i);

  always_comb begin
    code_c = VS_REG;
    mv_c   = '0;
    if (en_i) begin
      unique case (pin_c)
        PIN_LOW:  code_c = VS_REG;
        PIN_HIGH: code_c = VS_FIX_HI;
        default:  code_c = VS_FIX_LO; // open and the invalid code
      endcase
      case (code_c)
        VS_FIX_LO: mv_c = rail_i ? MV_R3_LO : MV_R1_LO;
        VS_FIX_HI: mv_c = rail_i ? MV_R3_HI : MV_R1_HI;
        default:   mv_c = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= VS_REG;
      mv_q   <= '0;
      rail_q <= 1'b0;
    end else begin
      code_q <= code_c;
      mv_q   <= mv_c;
      rail_q <= en_i & rail_i;
    end
  end

  assign rail_o = rail_q;
  assign code_o = code_q;
  assign mv_o   = mv_q;

  p_rail1_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !rail_i && pin_code_i == 2'b10 |=> code_o == 2'd2 && mv_o == MV_R1_HI);
  p_rail3_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rail_i && pin_code_i == 2'b01 |=> code_o == 2'd1 && mv_o == MV_R3_LO);
  p_low_reg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_code_i == 2'b00 |=> code_o == 2'd0 && mv_o == '0);
endmodule

// File: rtl/mfp_pin_ctrl.sv
`timescale 1ns/1ps
module mfp_pin_ctrl
  import mfp_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_MS = 80,
  parameter int SLOT_W     = 3,
  parameter int MV_W       = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              role_vsel_i,
  input  logic              dir_in_i,
  input  logic              on_pol_i,
  input  logic              out_src_seq_i,
  input  logic              gpio_en_i,
  input  logic [SLOT_W-1:0] assign_slot_i,
  input  logic              seq_active_i,
  input  logic [SLOT_W-1:0] seq_slot_i,
  input  logic              seq_abort_i,
  input  logic              timeout_clr_i,
  input  logic [1:0]        pin_code_i,
  input  logic              rail_sel_i,
  output logic              pin_oe_o,
  output logic              pin_out_o,
  output logic              seq_hold_o,
  output logic              timeout_o,
  output logic              init_req_o,
  output logic              vsel_valid_o,
  output logic              vsel_rail_o,
  output logic [1:0]        vsel_code_o,
  output logic [MV_W-1:0]   vsel_mv_o
);
  logic role_q, cfg_done_q;
  logic gpio_in_c, gpio_out_c, at_slot_c;
  logic level_raw_c, level_s;

  // role is captured once per reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      role_q     <= 1'b0;
      cfg_done_q <= 1'b0;
    end else if (!cfg_done_q) begin
      role_q     <= role_vsel_i;
      cfg_done_q <= 1'b1;
    end
  end

  assign gpio_in_c   = ~role_q & dir_in_i;
  assign gpio_out_c  = ~role_q & ~dir_in_i;
  assign at_slot_c   = (seq_slot_i == assign_slot_i);
  assign level_raw_c = (pin_code_e'(pin_code_i) == PIN_HIGH);

  mfp_sync #(.W(1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (level_raw_c),
    .q_o   (level_s)
  );

  mfp_seq_gate #(
    .CLK_HZ    (CLK_HZ),
    .TIMEOUT_MS(TIMEOUT_MS)
  ) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (gpio_in_c),
    .seq_active_i(seq_active_i),
    .at_slot_i   (at_slot_c),
    .level_i     (level_s),
    .on_pol_i    (on_pol_i),
    .abort_i     (seq_abort_i),
    .clr_i       (timeout_clr_i),
    .hold_o      (seq_hold_o),
    .timeout_o   (timeout_o),
    .init_req_o  (init_req_o)
  );

  mfp_out_ctl u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (gpio_out_c),
    .src_seq_i   (out_src_seq_i),
    .gpio_en_i   (gpio_en_i),
    .seq_active_i(seq_active_i),
    .at_slot_i   (at_slot_c),
    .abort_i     (seq_abort_i),
    .pin_out_o   (pin_out_o)
  );

  mfp_vsel_dec #(.MV_W(MV_W)) u_vsel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (role_q),
    .rail_i    (rail_sel_i),
    .pin_code_i(pin_code_i),
    .rail_o    (vsel_rail_o),
    .code_o    (vsel_code_o),
    .mv_o      (vsel_mv_o)
  );

  assign pin_oe_o     = gpio_out_c;
  assign vsel_valid_o = role_q;

  p_role_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_q |=> $stable(role_q));
  p_vsel_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsel_valid_o |-> !pin_oe_o && !seq_hold_o);
  p_out_only_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_out_o |-> pin_oe_o);
endmodule

// File: tb/tb_mfp_pin_ctrl.sv
`timescale 1ns/1ps
module tb_mfp_pin_ctrl;
  localparam int CLK_HZ = 50_000;
  localparam int TMO_MS = 80;
  localparam int WIN    = CLK_HZ / 1000 * TMO_MS; // 4000 edges
  localparam int SLOT_W = 3;
  localparam int MV_W   = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic role_vsel = 1'b0, dir_in = 1'b0, on_pol = 1'b1, out_src_seq = 1'b0, gpio_en = 1'b0;
  logic [SLOT_W-1:0] assign_slot = 3'd3, seq_slot = 3'd0;
  logic seq_active = 1'b0, seq_abort = 1'b0, tmo_clr = 1'b0, rail_sel = 1'b0;
  logic [1:0] pin_code = 2'b00;
  logic pin_oe, pin_out, seq_hold, tmo, init_req, vsel_valid, vsel_rail;
  logic [1:0] vsel_code;
  logic [MV_W-1:0] vsel_mv;

  int checks = 0;
  int errors = 0;

  mfp_pin_ctrl #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMO_MS), .SLOT_W(SLOT_W), .MV_W(MV_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .role_vsel_i(role_vsel), .dir_in_i(dir_in),
    .on_pol_i(on_pol), .out_src_seq_i(out_src_seq), .gpio_en_i(gpio_en),
    .assign_slot_i(assign_slot), .seq_active_i(seq_active), .seq_slot_i(seq_slot),
    .seq_abort_i(seq_abort), .timeout_clr_i(tmo_clr), .pin_code_i(pin_code),
    .rail_sel_i(rail_sel), .pin_oe_o(pin_oe), .pin_out_o(pin_out),
    .seq_hold_o(seq_hold), .timeout_o(tmo), .init_req_o(init_req),
    .vsel_valid_o(vsel_valid), .vsel_rail_o(vsel_rail), .vsel_code_o(vsel_code),
    .vsel_mv_o(vsel_mv)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // all stimulus changes and samples happen at falling edges
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic role);
    rst_n = 1'b0;
    role_vsel = role;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    chk("R1 reset vsel_valid", vsel_valid, 0);
    chk("R6 reset timeout", tmo, 0);
    chk("R4 reset init_req", init_req, 0);
    chk("R3 reset hold", seq_hold, 0);
  endtask

  task automatic t_role_r1;
    do_reset(1'b1);
    chk("R1 role vsel captured", vsel_valid, 1);
    role_vsel = 1'b0;
    tick(3);
    chk("R1 role change ignored", vsel_valid, 1);
    chk("R1 oe stays off", pin_oe, 0);
    do_reset(1'b0);
    role_vsel = 1'b1;
    tick(2);
    chk("R1 gpio role kept", vsel_valid, 0);
    chk("R1 gpio oe", pin_oe, 1);
  endtask

  task automatic t_dir_r2;
    dir_in = 1'b1; #1;
    chk("R2 input oe", pin_oe, 0);
    tick(1);
    dir_in = 1'b0; #1;
    chk("R2 output oe", pin_oe, 1);
    tick(1);
  endtask

  task automatic t_out_reg_r7;
    out_src_seq = 1'b0;
    gpio_en = 1'b1; #1;
    chk("R7 reg out high", pin_out, 1);
    tick(1);
    gpio_en = 1'b0; #1;
    chk("R7 reg out low", pin_out, 0);
    tick(1);
  endtask

  task automatic t_out_seq_r8;
    out_src_seq = 1'b1;
    seq_active = 1'b1;
    seq_slot = 3'd2;
    tick(1);
    chk("R8 before slot", pin_out, 0);
    seq_slot = 3'd3; #1;
    chk("R8 same cycle still low", pin_out, 0);
    tick(1);
    chk("R8 slot reached", pin_out, 1);
    seq_slot = 3'd4;
    gpio_en = 1'b1;
    tick(2);
    chk("R8 held after slot", pin_out, 1);
    gpio_en = 1'b0;
    seq_abort = 1'b1;
    tick(1);
    seq_abort = 1'b0;
    chk("R8 abort clears", pin_out, 0);
    seq_active = 1'b0;
    out_src_seq = 1'b0;
    tick(1);
  endtask

  task automatic t_gate_r3;
    dir_in = 1'b1;
    on_pol = 1'b1;
    pin_code = 2'b00;
    tick(2);
    seq_slot = 3'd5;
    seq_active = 1'b1; #1;
    chk("R3 other slot no hold", seq_hold, 0);
    seq_slot = 3'd3; #1;
    chk("R3 hold at slot", seq_hold, 1);
    pin_code = 2'b10;
    tick(1);
    chk("R3 hold one clock after change", seq_hold, 1);
    tick(1);
    chk("R3 release after sync", seq_hold, 0);
    on_pol = 1'b0; #1;
    chk("R3 active-low pol holds on high", seq_hold, 1);
    pin_code = 2'b01;
    tick(2);
    chk("R3 open counts as low", seq_hold, 0);
    seq_active = 1'b0;
    on_pol = 1'b1;
    pin_code = 2'b00;
    tick(2);
  endtask

  task automatic t_timeout_r4;
    seq_active = 1'b1;
    tick(WIN - 1);
    chk("R4 no timeout one edge early", tmo, 0);
    chk("R4 no init early", init_req, 0);
    tick(1);
    chk("R4 timeout at window", tmo, 1);
    chk("R4 init pulse", init_req, 1);
    tick(1);
    chk("R4 init pulse single", init_req, 0);
  endtask

  task automatic t_sticky_r6;
    seq_active = 1'b0;
    tick(5);
    chk("R6 sticky after wait ends", tmo, 1);
    tmo_clr = 1'b1;
    tick(1);
    tmo_clr = 1'b0;
    chk("R6 cleared by strobe", tmo, 0);
  endtask

  task automatic t_restart_r5;
    seq_active = 1'b1;
    tick(3000);
    seq_active = 1'b0;
    tick(1);
    seq_active = 1'b1;
    tick(WIN - 1);
    chk("R5 restart after wait drop", tmo, 0);
    seq_abort = 1'b1;
    tick(1);
    seq_abort = 1'b0;
    tick(WIN - 1);
    chk("R5 restart after abort", tmo, 0);
    tick(1);
    chk("R5 fires after full window", tmo, 1);
    seq_active = 1'b0;
    tmo_clr = 1'b1;
    tick(1);
    tmo_clr = 1'b0;
  endtask

  task automatic vs_step(input logic [1:0] code, input int exp_code, input int exp_mv,
                         input string req);
    pin_code = code; #1;
    tick(1);
    chk({req, " code"}, vsel_code, exp_code);
    chk({req, " mv"}, vsel_mv, exp_mv);
  endtask

  task automatic t_vsel_r9_r10_r11;
    do_reset(1'b1);
    rail_sel = 1'b0;
    pin_code = 2'b00;
    tick(1);
    chk("R9 rail id", vsel_rail, 0);
    vs_step(2'b00, 0, 0,    "R9 low");
    pin_code = 2'b01; #1;
    chk("R11 no change before edge", vsel_code, 0);
    vs_step(2'b01, 1, 750,  "R9 open");
    vs_step(2'b10, 2, 1100, "R9 high");
    vs_step(2'b11, 1, 750,  "R9 invalid as open");
    rail_sel = 1'b1;
    vs_step(2'b00, 0, 0,    "R10 low");
    chk("R10 rail id", vsel_rail, 1);
    vs_step(2'b01, 1, 1100, "R10 open");
    vs_step(2'b10, 2, 1200, "R10 high");
    dir_in = 1'b1;
    on_pol = 1'b1;
    pin_code = 2'b00;
    seq_active = 1'b1;
    seq_slot = 3'd3;
    tick(3);
    chk("R11 no hold in vsel", seq_hold, 0);
    dir_in = 1'b0; #1;
    chk("R11 no oe in vsel", pin_oe, 0);
    seq_active = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_role_r1();
    t_dir_r2();
    t_out_reg_r7();
    t_out_seq_r8();
    t_gate_r3();
    t_timeout_r4();
    t_sticky_r6();
    t_restart_r5();
    t_vsel_r9_r10_r11();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100_000);
    checks++;
    errors++;
    $display("FAIL watchdog: got running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule